// File: doc/BRIEF.md
# Multi-Bank Memory Interlock Arbiter

This block decides, once per memory cycle, which requesting sections may start an access on a set of independent memory banks. The requesters are one or more DMA synchronizers, one I/O control processor and two compute units. Each requester presents a request and a bank number. In the same cycle it gets back exactly one of two pulses: a grant or a lockout. A section that is locked out retries in a later cycle.

A bank that is granted in one cycle is busy for the whole next cycle, and every request to it in that cycle is locked out. When two or more requests target the same free bank, the fixed priority decides the winner. The order is DMA synchronizers first, then the I/O processor, then the compute units. Requests to different banks proceed in parallel.

To stop the I/O path from starving, a DMA synchronizer or the I/O processor that is locked out reserves that bank. While the reservation stands, lower-class requesters are locked out of the bank even when it is free. The reservation ends in the cycle its owner is granted. One clock of the block is one memory cycle.

Top module: `bank_interlock_arbiter`

## Requirements
- R1: After reset no bank is busy and no reservation exists, so requests to distinct in-range banks are all granted.
- R2: In every cycle each requester with `req_i` high sees exactly one of `grant_o` or `lock_o` high, and a requester with `req_i` low sees neither.
- R3: A bank granted in cycle t locks out every request to it in cycle t+1. If it is not granted in t+1, it can be granted again in t+2.
- R4: Grants to different banks in the same cycle are independent of each other.
- R5: Requester index sets the priority, with the lowest index highest. Indices 0 to N_DMA-1 are the DMA synchronizers, N_DMA is the I/O processor, N_DMA+1 is compute unit 1 and N_DMA+2 is compute unit 2. Among the eligible requests to one free bank, only the lowest index is granted.
- R6: When both compute units target the same free bank, compute unit 1 (index N_DMA+1) is granted and compute unit 2 is locked out.
- R7: A DMA synchronizer or the I/O processor that is locked out reserves the bank. While it is reserved, requesters of a lower class (DMA above I/O above compute) are locked out of it even when it is free. Compute unit lockouts make no reservation.
- R8: A reservation clears in the cycle its owner is granted on that bank. After that, lower-class requesters win the bank again once it is no longer busy.
- R9: If a higher-priority (lower-index) DMA or I/O requester is locked out on a bank that another requester has reserved, it takes over the reservation.
- R10: A request whose bank number is N_BANK or above is locked out and changes no busy or reservation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DMA+3 | Request per requester, index order as in R5 |
| bank_i | input | (N_DMA+3) x BW | Target bank number per requester |
| grant_o | output | N_DMA+3 | Grant pulse per requester, same cycle |
| lock_o | output | N_DMA+3 | Lockout pulse per requester, same cycle |

## Verification
The hardest situation to reach from the ports is a free bank that still locks out a compute unit, and then a change of reservation owner. The stimulus first makes a compute unit occupy a bank. It then makes the I/O processor collide with the busy bank so that it takes a reservation. Next a DMA synchronizer wins the bank, and a second DMA synchronizer hits it while it is busy, so that ownership moves up. Between these steps, lone lower-class requests are sent to the reserved bank while it is free, and each one must be locked out. A long random phase, compared every cycle with a behavioural model, covers the cases where all of these interact.

// File: rtl/bil_pkg.sv
package bil_pkg;
  typedef enum logic [1:0] {
    CLS_CU  = 2'd0,
    CLS_IOP = 2'd1,
    CLS_DMA = 2'd2
  } req_cls_e;

  function automatic req_cls_e cls_of(input int idx, input int n_dma);
    if (idx < n_dma) return CLS_DMA;
    if (idx == n_dma) return CLS_IOP;
    return CLS_CU;
  endfunction
endpackage

// File: rtl/bil_busy_track.sv
module bil_busy_track #(
  parameter int N_BANK = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BANK-1:0] bank_gnt_i,
  output logic [N_BANK-1:0] busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_o <= '0;
    else         busy_o <= bank_gnt_i;
  end
endmodule

// File: rtl/bil_resolve.sv
module bil_resolve
  import bil_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int N_DMA  = 1,
  parameter int N_REQ  = N_DMA + 3,
  parameter int BW     = 3,
  parameter int OW     = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_REQ-1:0]             req_i,
  input  logic [N_REQ-1:0][BW-1:0]     bank_i,
  input  logic [N_BANK-1:0]            busy_i,
  input  logic [N_BANK-1:0]            rv_i,
  input  logic [N_BANK-1:0][OW-1:0]    ro_i,
  output logic [N_REQ-1:0]             rng_o,
  output logic [N_REQ-1:0]             grant_o,
  output logic [N_REQ-1:0]             lock_o,
  output logic [N_BANK-1:0]            bank_gnt_o
);
  logic [N_REQ-1:0][BW-1:0] bsel;
  logic [N_REQ-1:0]         barred;
  logic [N_REQ-1:0]         elig;

  for (genvar r = 0; r < N_REQ; r++) begin : g_req
    assign rng_o[r]  = (32'(bank_i[r]) < N_BANK);
    assign bsel[r]   = rng_o[r] ? bank_i[r] : '0;
    // lower class than the reservation owner is held off
    assign barred[r] = rv_i[bsel[r]] &&
                       (cls_of(r, N_DMA) < cls_of(int'(ro_i[bsel[r]]), N_DMA));
    assign elig[r]   = req_i[r] && rng_o[r] && !busy_i[bsel[r]] && !barred[r];

    a_r7_resv_honoured: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[r] && rv_i[bank_i[r]]) |->
        (cls_of(r, N_DMA) >= cls_of(int'(ro_i[bank_i[r]]), N_DMA)));
    a_r10_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[r] && !rng_o[r]) |-> (lock_o[r] && !grant_o[r]));
  end

  // index order is priority order: first eligible per bank wins
  always_comb begin
    bank_gnt_o = '0;
    grant_o    = '0;
    for (int r = 0; r < N_REQ; r++) begin
      if (elig[r] && !bank_gnt_o[bsel[r]]) begin
        grant_o[r]             = 1'b1;
        bank_gnt_o[bsel[r]]    = 1'b1;
      end
    end
  end

  assign lock_o = req_i & ~grant_o;
endmodule

// File: rtl/bil_resv_table.sv
module bil_resv_table
  import bil_pkg::*;
#(
  parameter int N_BANK = 8,
  parameter int N_DMA  = 1,
  parameter int N_REQ  = N_DMA + 3,
  parameter int BW     = 3,
  parameter int OW     = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_REQ-1:0]          grant_i,
  input  logic [N_REQ-1:0]          lock_i,
  input  logic [N_REQ-1:0]          rng_i,
  input  logic [N_REQ-1:0][BW-1:0]  bank_i,
  output logic [N_BANK-1:0]         rv_o,
  output logic [N_BANK-1:0][OW-1:0] ro_o
);
  logic [N_BANK-1:0]         clr;
  logic [N_BANK-1:0]         cand_v;
  logic [N_BANK-1:0][OW-1:0] cand;

  always_comb begin
    for (int b = 0; b < N_BANK; b++) begin
      clr[b]    = rv_o[b] && grant_i[ro_o[b]] && (32'(bank_i[ro_o[b]]) == b);
      cand_v[b] = 1'b0;
      cand[b]   = '0;
      // descending scan leaves the highest-priority lockout
      for (int r = N_REQ - 1; r >= 0; r--) begin
        if (lock_i[r] && rng_i[r] && (32'(bank_i[r]) == b) &&
            (cls_of(r, N_DMA) != CLS_CU)) begin
          cand_v[b] = 1'b1;
          cand[b]   = OW'(r);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_o <= '0;
      ro_o <= '0;
    end else begin
      for (int b = 0; b < N_BANK; b++) begin
        if (cand_v[b] && (!(rv_o[b] && !clr[b]) || (cand[b] < ro_o[b]))) begin
          rv_o[b] <= 1'b1;
          ro_o[b] <= cand[b];
        end else if (clr[b]) begin
          rv_o[b] <= 1'b0;
        end
      end
    end
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_chk
    a_r8_owner_served_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rv_o[b] && grant_i[ro_o[b]] && (32'(bank_i[ro_o[b]]) == b) && !cand_v[b])
        |=> !rv_o[b]);
    a_r9_takeover: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rv_o[b] && cand_v[b] && (cand[b] < ro_o[b])) |=> (rv_o[b] && ro_o[b] == $past(cand[b])));
  end
endmodule

// File: rtl/bank_interlock_arbiter.sv
module bank_interlock_arbiter #(
  parameter int N_BANK = 8,
  parameter int N_DMA  = 1,
  localparam int N_REQ = N_DMA + 3,
  localparam int BW    = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int OW    = $clog2(N_REQ)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_REQ-1:0]         req_i,
  input  logic [N_REQ-1:0][BW-1:0] bank_i,
  output logic [N_REQ-1:0]         grant_o,
  output logic [N_REQ-1:0]         lock_o
);
  logic [N_BANK-1:0]         busy;
  logic [N_BANK-1:0]         bank_gnt;
  logic [N_BANK-1:0]         rv;
  logic [N_BANK-1:0][OW-1:0] ro;
  logic [N_REQ-1:0]          rng;

  bil_resolve #(.N_BANK(N_BANK), .N_DMA(N_DMA), .N_REQ(N_REQ), .BW(BW), .OW(OW)) u_resolve (
    .clk_i, .rst_ni, .req_i, .bank_i,
    .busy_i(busy), .rv_i(rv), .ro_i(ro),
    .rng_o(rng), .grant_o, .lock_o, .bank_gnt_o(bank_gnt)
  );

  bil_busy_track #(.N_BANK(N_BANK)) u_busy (
    .clk_i, .rst_ni, .bank_gnt_i(bank_gnt), .busy_o(busy)
  );

  bil_resv_table #(.N_BANK(N_BANK), .N_DMA(N_DMA), .N_REQ(N_REQ), .BW(BW), .OW(OW)) u_resv (
    .clk_i, .rst_ni, .grant_i(grant_o), .lock_i(lock_o), .rng_i(rng), .bank_i,
    .rv_o(rv), .ro_o(ro)
  );

  a_r2_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o | lock_o) == req_i) && ((grant_o & lock_o) == '0));
  a_r3_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bank_gnt) & bank_gnt) == '0);
  a_r6_cu_tie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[N_DMA+1] && req_i[N_DMA+2] && bank_i[N_DMA+1] == bank_i[N_DMA+2])
      |-> !grant_o[N_DMA+2]);
endmodule

// File: tb/sim_bank_interlock_arbiter.sv
module sim_bank_interlock_arbiter;
  localparam int NB = 6;
  localparam int ND = 2;
  localparam int NR = ND + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] req = '0;
  logic [NR-1:0][2:0] bank = '0;
  logic [NR-1:0] grant, lock;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R2";

  int m_busy[8];
  int m_rv[8];
  int m_ro[8];

  always #2 clk = ~clk;

  bank_interlock_arbiter #(.N_BANK(NB), .N_DMA(ND)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bank_i(bank),
    .grant_o(grant), .lock_o(lock)
  );

  function automatic int cls(input int r);
    if (r < ND) return 2;
    if (r == ND) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 8; b++) begin
      m_busy[b] = 0; m_rv[b] = 0; m_ro[b] = 0;
    end
  endtask

  // behavioural reference: compute expected, compare, advance state
  task automatic model_cycle();
    logic [NR-1:0] eg, el;
    int taken[8];
    int bk;
    eg = '0; el = '0;
    for (int b = 0; b < 8; b++) taken[b] = 0;
    for (int r = 0; r < NR; r++) begin
      if (req[r]) begin
        bk = int'(bank[r]);
        if (bk >= NB) el[r] = 1'b1;
        else if (m_busy[bk] != 0 || taken[bk] != 0) el[r] = 1'b1;
        else if (m_rv[bk] != 0 && cls(r) < cls(m_ro[bk])) el[r] = 1'b1;
        else begin eg[r] = 1'b1; taken[bk] = 1; end
      end
    end
    check({cur_tag, " grant"}, grant, eg);
    check({cur_tag, " lock"}, lock, el);
    for (int b = 0; b < 8; b++) begin
      if (m_rv[b] != 0 && eg[m_ro[b]] && int'(bank[m_ro[b]]) == b) m_rv[b] = 0;
    end
    for (int r = 0; r < NR; r++) begin
      bk = int'(bank[r]);
      if (el[r] && bk < NB && cls(r) > 0) begin
        if (m_rv[bk] == 0 || r < m_ro[bk]) begin m_rv[bk] = 1; m_ro[bk] = r; end
      end
    end
    for (int b = 0; b < 8; b++) m_busy[b] = taken[b];
  endtask

  task automatic step(input logic [NR-1:0] rq, input int b0, input int b1, input int b2,
                      input int b3, input int b4);
    @(negedge clk);
    req = rq;
    bank[0] = 3'(b0); bank[1] = 3'(b1); bank[2] = 3'(b2);
    bank[3] = 3'(b3); bank[4] = 3'(b4);
    #1;
    model_cycle();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // bit index: 0 DMA0, 1 DMA1, 2 IOP, 3 CU1, 4 CU2
  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    check("R2 reset grant", grant, '0);
    check("R2 reset lock", lock, '0);
    rst_n = 1'b1;

    cur_tag = "R1";
    step(5'b11111, 0, 1, 2, 3, 4);
    check("R1 all granted", grant, 5'b11111);
    check("R4 parallel banks", lock, 5'b00000);

    cur_tag = "R3";
    step(5'b01000, 0, 0, 0, 0, 0);
    check("R3 busy lockout", grant, 5'b00000);
    step(5'b01000, 0, 0, 0, 0, 0);
    check("R3 free again", grant, 5'b01000);

    cur_tag = "R5";
    step(5'b11111, 5, 5, 5, 5, 5);
    check("R5 dma wins", grant, 5'b00001);

    cur_tag = "R6";
    step(5'b11000, 0, 0, 0, 2, 2);
    check("R6 cu1 wins", grant, 5'b01000);

    cur_tag = "R7";
    step(5'b01000, 0, 0, 0, 3, 0);
    step(5'b00100, 0, 0, 3, 0, 0);
    check("R7 iop locked busy", lock, 5'b00100);
    step(5'b10000, 0, 0, 0, 0, 3);
    check("R7 cu2 barred on free bank", lock, 5'b10000);
    cur_tag = "R8";
    step(5'b00100, 0, 0, 3, 0, 0);
    check("R8 owner granted", grant, 5'b00100);
    step(5'b10000, 0, 0, 0, 0, 3);
    check("R8 busy after owner", grant, 5'b00000);
    step(5'b10000, 0, 0, 0, 0, 3);
    check("R8 cu2 wins after clear", grant, 5'b10000);

    cur_tag = "R9";
    step(5'b01000, 0, 0, 0, 4, 0);
    step(5'b00100, 0, 0, 4, 0, 0);
    step(5'b00101, 4, 0, 4, 0, 0);
    check("R9 dma0 beats owner", grant, 5'b00001);
    step(5'b00010, 0, 4, 0, 0, 0);
    check("R9 dma1 locked busy", lock, 5'b00010);
    step(5'b00100, 0, 0, 4, 0, 0);
    check("R9 iop barred after takeover", lock, 5'b00100);
    step(5'b00010, 0, 4, 0, 0, 0);
    check("R9 new owner granted", grant, 5'b00010);

    cur_tag = "R10";
    step(5'b11111, 6, 7, 6, 7, 6);
    check("R10 out of range locked", lock, 5'b11111);
    step(5'b10000, 0, 0, 0, 0, 1);
    check("R10 no state effect", grant, 5'b10000);

    cur_tag = "R2";
    for (int i = 0; i < 600; i++) begin
      step(5'($urandom), int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
           int'($urandom_range(0, 5)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 5)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule